// File: doc/BRIEF.md
# Conditional Floating-Point Register Move Unit

This block decides whether one floating-point register write takes place. The decision depends on a condition chosen by a 4-bit sub-opcode. Four sub-opcodes test a 32-bit integer operand against zero, and the signed tests read only its sign bit. Two sub-opcodes test one selected bit of a 16-bit boolean register. When the condition holds, the destination takes the source value exactly as given. When it fails, the write-enable stays low and the write data carries the old destination value, so the destination keeps its contents.

The surrounding pipeline gives the operands with a one-cycle valid strobe. One cycle later it gets a registered write-enable, write data and an illegal-operation flag. Two kinds of operation raise the flag: a boolean-bit move while the boolean option is absent, and a reserved sub-opcode. Sub-opcodes 1 to 7 are floating-point compares that another unit executes. This block neither writes nor flags for them. The register file and hazard logic are outside this block.

Top module: `fp_cond_move`

## Requirements
- R1: Sub-opcode 8 (move-if-zero) asserts the write-enable only when the integer operand is all zeros.
- R2: Sub-opcode 9 (move-if-nonzero) asserts the write-enable only when the integer operand has at least one bit set.
- R3: Sub-opcode 10 (move-if-negative) asserts the write-enable only when bit 31 of the integer operand is 1.
- R4: Sub-opcode 11 (move-if-not-negative) asserts the write-enable only when bit 31 of the integer operand is 0, which includes zero.
- R5: Sub-opcode 12 moves when bit `bool_sel` of `bool_reg` is 0, and sub-opcode 13 moves when that bit is 1. Bit 0 is the LSB, and all 16 positions can be selected.
- R6: When the condition fails, the write-enable is low and the write data equals the old destination value given with the strobe.
- R7: Sub-opcodes 12 and 13 raise the illegal flag with no write when `bool_opt_en` is 0.
- R8: Sub-opcodes 0, 14 and 15 raise the illegal flag with no write.
- R9: Sub-opcodes 1 to 7 produce neither a write nor the illegal flag.
- R10: A moved value is copied bit for bit, NaN patterns included.
- R11: The outputs appear on the cycle after a strobe and last one cycle. The write-enable and the illegal flag are never high together, and both are low after a cycle without a strobe.
- R12: While reset is low, the write-enable, the illegal flag and the write data are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| sub_op | input | 4 | Sub-opcode selecting the condition |
| int_val | input | 32 | Integer operand tested against zero |
| bool_reg | input | 16 | Boolean register contents |
| bool_sel | input | 4 | Index of the boolean bit to test |
| src_val | input | 32 | Source floating-point value |
| old_val | input | 32 | Current destination floating-point value |
| bool_opt_en | input | 1 | 1 when the boolean option is present |
| wr_en | output | 1 | Destination write-enable |
| wr_data | output | 32 | Destination write data |
| illegal | output | 1 | Illegal-operation flag |

## Verification
The assertions assume that `in_valid`, `sub_op`, `src_val` and `old_val` are known on every clock edge after reset. They also assume that operands are sampled only on the edge where the strobe is high. The bench sets every input to a known value at time zero. It changes inputs only on falling edges and holds each operation for exactly one rising edge, then drops the strobe. This gives at least one cycle without a strobe between operations, so the idle-output property is exercised. The bench also holds `bool_opt_en` steady within each operation.

// File: rtl/fpcm_pkg.sv
// Shared types for the conditional FP move unit.
// Assumes a 4-bit sub-opcode field whose values 8..13 select move conditions.
package fpcm_pkg;

    // Sub-opcode values that the decode recognises
    localparam logic [3:0] OPC_MOV_EQZ = 4'd8;
    localparam logic [3:0] OPC_MOV_NEZ = 4'd9;
    localparam logic [3:0] OPC_MOV_LTZ = 4'd10;
    localparam logic [3:0] OPC_MOV_GEZ = 4'd11;
    localparam logic [3:0] OPC_MOV_BF  = 4'd12;
    localparam logic [3:0] OPC_MOV_BT  = 4'd13;

    // Which condition drives the move decision
    typedef enum logic [2:0] {
        COND_NONE = 3'd0,
        COND_EQZ  = 3'd1,
        COND_NEZ  = 3'd2,
        COND_LTZ  = 3'd3,
        COND_GEZ  = 3'd4,
        COND_BF   = 3'd5,
        COND_BT   = 3'd6
    } cond_sel_e;

endpackage

// File: rtl/fpcm_decode.sv
// Sub-opcode decode: maps the sub-opcode to a condition selector and flags
// reserved or unavailable encodings. Assumes compares (1..7) are handled
// by another unit and are neither moves nor illegal here.
module fpcm_decode
    import fpcm_pkg::*;
(
    input  logic [3:0] sub_op,
    input  logic       bool_opt_en,
    output cond_sel_e  cond_sel,
    output logic       op_illegal
);

    // Purpose: select the condition and legality for each sub-opcode
    always_comb begin
        cond_sel   = COND_NONE;
        op_illegal = 1'b0;
        unique case (sub_op)
            OPC_MOV_EQZ: cond_sel = COND_EQZ;
            OPC_MOV_NEZ: cond_sel = COND_NEZ;
            OPC_MOV_LTZ: cond_sel = COND_LTZ;
            OPC_MOV_GEZ: cond_sel = COND_GEZ;
            OPC_MOV_BF,
            OPC_MOV_BT: begin
                if (bool_opt_en)
                    cond_sel = (sub_op == OPC_MOV_BT) ? COND_BT : COND_BF;
                else
                    op_illegal = 1'b1;
            end
            4'd0, 4'd14, 4'd15: op_illegal = 1'b1;
            default: cond_sel = COND_NONE;
        endcase
    end

endmodule

// File: rtl/fpcm_int_test.sv
// Integer operand zero tests: equality with zero and sign as two's complement.
// Assumes INT_W >= 2.
module fpcm_int_test #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] int_val,
    output logic             is_zero,
    output logic             is_neg
);

    // Purpose: reduce the operand to zero and sign indications
    always_comb begin
        is_zero = ~|int_val;
        is_neg  = int_val[INT_W-1];
    end

    // Purpose: a zero operand can never read as negative
    always_comb begin
        if (!$isunknown(int_val)) begin
            // R3
            zero_not_neg_chk: assert (!(is_zero && is_neg));
        end
    end

endmodule

// File: rtl/fpcm_bool_pick.sv
// Boolean bit select: returns one bit of the boolean register by index.
// Assumes the index width covers every bit position.
module fpcm_bool_pick #(
    parameter int BOOL_W = 16,
    parameter int IDX_W  = $clog2(BOOL_W)
) (
    input  logic [BOOL_W-1:0] bool_reg,
    input  logic [IDX_W-1:0]  bool_sel,
    output logic              bit_val
);

    // Purpose: one-hot match of every position against the index
    logic [BOOL_W-1:0] hit;

    for (genvar i = 0; i < BOOL_W; i++) begin : g_pos
        assign hit[i] = (bool_sel == IDX_W'(i)) & bool_reg[i];
    end

    // Purpose: merge the one-hot matches into the selected bit
    always_comb bit_val = |hit;

endmodule

// File: rtl/fp_cond_move.sv
// Conditional floating-point register move unit.
// On each in_valid strobe it decides whether the destination is written with
// src_val; results are registered and visible for one cycle after the strobe.
// Assumes operands are stable on the strobe edge; the register file applies
// wr_data only when wr_en is high.
module fp_cond_move
    import fpcm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INT_W  = 32,
    parameter int BOOL_W = 16,
    localparam int IDX_W = $clog2(BOOL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        sub_op,
    input  logic [INT_W-1:0]  int_val,
    input  logic [BOOL_W-1:0] bool_reg,
    input  logic [IDX_W-1:0]  bool_sel,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] old_val,
    input  logic              bool_opt_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              illegal
);

    cond_sel_e cond_sel;
    logic      op_illegal;
    logic      is_zero;
    logic      is_neg;
    logic      bit_val;
    logic      move_ok;

    logic              wr_en_q;
    logic              illegal_q;
    logic [DATA_W-1:0] wr_data_q;

    fpcm_decode u_decode (
        .sub_op      (sub_op),
        .bool_opt_en (bool_opt_en),
        .cond_sel    (cond_sel),
        .op_illegal  (op_illegal)
    );

    fpcm_int_test #(.INT_W(INT_W)) u_int_test (
        .int_val (int_val),
        .is_zero (is_zero),
        .is_neg  (is_neg)
    );

    fpcm_bool_pick #(.BOOL_W(BOOL_W), .IDX_W(IDX_W)) u_bool_pick (
        .bool_reg (bool_reg),
        .bool_sel (bool_sel),
        .bit_val  (bit_val)
    );

    // Purpose: evaluate the selected condition into a move decision
    always_comb begin
        unique case (cond_sel)
            COND_EQZ: move_ok = is_zero;
            COND_NEZ: move_ok = !is_zero;
            COND_LTZ: move_ok = is_neg;
            COND_GEZ: move_ok = !is_neg;
            COND_BF:  move_ok = !bit_val;
            COND_BT:  move_ok = bit_val;
            default:  move_ok = 1'b0;
        endcase
    end

    // Purpose: register the write decision, data and illegal flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            illegal_q <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q   <= in_valid && move_ok;
            illegal_q <= in_valid && op_illegal;
            wr_data_q <= move_ok ? src_val : old_val;
        end
    end

    assign wr_en   = wr_en_q;
    assign illegal = illegal_q;
    assign wr_data = wr_data_q;

    // R11
    wr_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_q && illegal_q));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en_q && !illegal_q));

    // R6
    fail_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wr_en_q || wr_data_q == $past(old_val)));

    // R10
    exact_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!wr_en_q || wr_data_q == $past(src_val)));

    // R7
    bool_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bool_opt_en && (sub_op == OPC_MOV_BF || sub_op == OPC_MOV_BT))
        |=> (illegal_q && !wr_en_q));

endmodule

// File: tb/fp_cond_move_test.sv
// Directed bench for the conditional FP move unit: one task per scenario.
module fp_cond_move_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  sub_op = 4'd0;
    logic [31:0] int_val = '0;
    logic [15:0] bool_reg = '0;
    logic [3:0]  bool_sel = '0;
    logic [31:0] src_val = '0;
    logic [31:0] old_val = '0;
    logic        bool_opt_en = 1'b1;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_cond_move uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
        .int_val(int_val), .bool_reg(bool_reg), .bool_sel(bool_sel),
        .src_val(src_val), .old_val(old_val), .bool_opt_en(bool_opt_en),
        .wr_en(wr_en), .wr_data(wr_data), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one strobed operation and check the registered result
    task automatic run_op(input string req, input logic [3:0] op,
                          input logic [31:0] iv, input logic [15:0] br,
                          input logic [3:0] idx, input logic [31:0] s,
                          input logic [31:0] o, input bit exp_we,
                          input bit exp_ill);
        logic [31:0] exp_d;
        @(negedge clk);
        in_valid = 1'b1; sub_op = op; int_val = iv; bool_reg = br;
        bool_sel = idx; src_val = s; old_val = o;
        @(negedge clk);
        in_valid = 1'b0;
        exp_d = exp_we ? s : o;
        check(wr_en == exp_we, req, "wr_en", 32'(wr_en), 32'(exp_we));
        check(illegal == exp_ill, req, "illegal", 32'(illegal), 32'(exp_ill));
        if (!exp_ill)
            check(wr_data == exp_d, req, "wr_data", wr_data, exp_d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(wr_en == 1'b0, "R12", "wr_en", 32'(wr_en), 32'd0);
        check(illegal == 1'b0, "R12", "illegal", 32'(illegal), 32'd0);
        check(wr_data == 32'd0, "R12", "wr_data", wr_data, 32'd0);
    endtask

    task automatic t_eqz();
        run_op("R1", 4'd8, 32'd0, '0, '0, 32'h3F80_0000, 32'h4000_0000, 1, 0);
        run_op("R1", 4'd8, 32'd1, '0, '0, 32'h3F80_0000, 32'h4000_0000, 0, 0);
        run_op("R1", 4'd8, 32'h8000_0000, '0, '0, 32'h1111_1111, 32'h2222_2222, 0, 0);
    endtask

    task automatic t_nez();
        run_op("R2", 4'd9, 32'd0, '0, '0, 32'hAAAA_0001, 32'h5555_0002, 0, 0);
        run_op("R2", 4'd9, 32'h0001_0000, '0, '0, 32'hAAAA_0001, 32'h5555_0002, 1, 0);
        run_op("R2", 4'd9, 32'hFFFF_FFFF, '0, '0, 32'hC0DE_0003, 32'h0BAD_0004, 1, 0);
    endtask

    task automatic t_ltz();
        run_op("R3", 4'd10, 32'h8000_0000, '0, '0, 32'h1234_5678, 32'h8765_4321, 1, 0);
        run_op("R3", 4'd10, 32'hFFFF_FFFF, '0, '0, 32'h1234_5678, 32'h8765_4321, 1, 0);
        run_op("R3", 4'd10, 32'd0, '0, '0, 32'h1234_5678, 32'h8765_4321, 0, 0);
        run_op("R3", 4'd10, 32'h7FFF_FFFF, '0, '0, 32'h1234_5678, 32'h8765_4321, 0, 0);
    endtask

    task automatic t_gez();
        run_op("R4", 4'd11, 32'd0, '0, '0, 32'hDEAD_BEEF, 32'hFEED_F00D, 1, 0);
        run_op("R4", 4'd11, 32'h7FFF_FFFF, '0, '0, 32'hDEAD_BEEF, 32'hFEED_F00D, 1, 0);
        run_op("R4", 4'd11, 32'h8000_0000, '0, '0, 32'hDEAD_BEEF, 32'hFEED_F00D, 0, 0);
    endtask

    task automatic t_bool();
        logic [15:0] pat;
        pat = 16'hA5C3;
        bool_opt_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            run_op("R5", 4'd13, 32'd0, pat, 4'(i), 32'h0000_1000 + 32'(i),
                   32'hFFFF_0000, pat[i], 0);
            run_op("R5", 4'd12, 32'd0, pat, 4'(i), 32'h0000_2000 + 32'(i),
                   32'hFFFF_0001, !pat[i], 0);
        end
    endtask

    task automatic t_fail_keeps();
        run_op("R6", 4'd8, 32'd7, '0, '0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, 0);
        run_op("R6", 4'd12, 32'd0, 16'h0001, 4'd0, 32'h0F0F_0F0F, 32'hCAFE_BABE, 0, 0);
    endtask

    task automatic t_bool_absent();
        bool_opt_en = 1'b0;
        run_op("R7", 4'd12, 32'd0, 16'h0000, 4'd3, 32'h1, 32'h2, 0, 1);
        run_op("R7", 4'd13, 32'd0, 16'hFFFF, 4'd3, 32'h1, 32'h2, 0, 1);
        bool_opt_en = 1'b1;
    endtask

    task automatic t_reserved();
        run_op("R8", 4'd0, 32'd0, '0, '0, 32'h1, 32'h2, 0, 1);
        run_op("R8", 4'd14, 32'd0, '0, '0, 32'h1, 32'h2, 0, 1);
        run_op("R8", 4'd15, 32'd0, '0, '0, 32'h1, 32'h2, 0, 1);
    endtask

    task automatic t_compares();
        for (int op = 1; op <= 7; op++)
            run_op("R9", 4'(op), 32'd0, 16'hFFFF, 4'd0, 32'hABCD_0000, 32'h0000_ABCD, 0, 0);
    endtask

    task automatic t_nan_copy();
        run_op("R10", 4'd8, 32'd0, '0, '0, 32'h7FA0_0001, 32'h0, 1, 0);
        run_op("R10", 4'd9, 32'd5, '0, '0, 32'hFFC1_2345, 32'h0, 1, 0);
        run_op("R10", 4'd11, 32'd1, '0, '0, 32'h8000_0000, 32'h0, 1, 0);
    endtask

    task automatic t_idle();
        run_op("R11", 4'd8, 32'd0, '0, '0, 32'h5, 32'h6, 1, 0);
        @(negedge clk);
        check(wr_en == 1'b0, "R11", "wr_en idle", 32'(wr_en), 32'd0);
        check(illegal == 1'b0, "R11", "illegal idle", 32'(illegal), 32'd0);
        run_op("R11", 4'd15, 32'd0, '0, '0, 32'h5, 32'h6, 0, 1);
        @(negedge clk);
        check(illegal == 1'b0, "R11", "illegal one cycle", 32'(illegal), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_eqz();
        t_nez();
        t_ltz();
        t_gez();
        t_bool();
        t_fail_keeps();
        t_bool_absent();
        t_reserved();
        t_compares();
        t_nan_copy();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule